// File: doc/BRIEF.md
# Multicycle Fetch-Execute Sequencer

This block is the control sequencer and register file of a small accumulator machine. The machine uses a 16-bit word: the top four bits hold the opcode and the low twelve bits hold an operand, which is either a value or a memory address. The sequencer walks each instruction through its register transfers one step per clock. The program counter is copied to the memory address register, the program counter is incremented, the addressed word is read into the memory data register, and that word is then moved into the instruction register. The instruction is decoded next. An operand read follows only when the instruction needs memory data. The instruction is executed last.

Program and data share one synchronous memory port. Read data returns one clock after the read strobe. At most one access is made in any cycle. Arithmetic is done by an external ALU. The sequencer drives the ALU operands and its add/subtract select, and captures the result and overflow indication.

Interrupt requests are tested only as an execute step ends. When the enable bit is set, the sequencer copies the program counter, the accumulator and the status register into a single shadow bank. It then jumps to a fixed service address with interrupts disabled. A return opcode copies the shadow bank back. A halt opcode freezes the sequencer.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is held, `pcOut`, `accOut` and `statusOut` are zero, and `halted`, `memRe`, `memWe` and `irqAck` are low.
- R2: Each fetch takes the following steps. In the first cycle the address register is loaded from the program counter. In the second cycle `memRe` is asserted with `memAddr` equal to the program counter, and the program counter then becomes its old value plus one. The word read goes into the data register in the third cycle and into the instruction register in the fourth.
- R3: An instruction with no data access takes 6 cycles from the start of its fetch to the start of the next fetch. A load from memory takes 9 cycles (operand read in its 7th cycle). A store takes 7 cycles (write in its 7th cycle).
- R4: `memRe` and `memWe` are never asserted in the same cycle.
- R5: Opcode 0x1 loads the zero-extended operand into the accumulator. Opcode 0x2 loads the word at the operand address. Neither opcode changes the flags.
- R6: Opcodes 0x4 (add value), 0x5 (add memory word), 0x6 (subtract value) and 0x7 (subtract memory word) behave as follows. `aluA` carries the accumulator. `aluB` carries the operand or the memory word. `aluFunc` is 1 for subtract. The accumulator takes `aluResult`. The status bits are set as follows: zero at bit 0, negative (result bit 15) at bit 1, and overflow (`aluOvf`) at bit 2. No other instruction changes these bits, except return-from-interrupt.
- R7: Opcode 0x3 writes the accumulator to the operand address.
- R8: Opcode 0x8 loads the operand into the program counter, so the next fetch comes from that address.
- R9: Opcode 0x9 sets the interrupt-enable bit (status bit 3), and opcode 0xA clears it.
- R10: If `irqReq` is high at the end of an execute step and the enable bit was already set, one save cycle follows. In that cycle `irqAck` is high. The program counter is then `ISR_ADDR`, the enable bit is clear, and the next fetch is taken from `ISR_ADDR`.
- R11: While the enable bit is clear, `irqReq` has no effect: fetching continues in program order and `irqAck` stays low.
- R12: Opcode 0xE restores the program counter, accumulator and status register saved on interrupt entry, so fetching resumes at the interrupted instruction.
- R13: After opcode 0xF executes, `halted` stays high, the program counter is frozen, and no further memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 12 | Memory address (address register) |
| memRe | output | 1 | Read strobe, data returned next cycle |
| memWe | output | 1 | Write strobe |
| memWdata | output | 16 | Write data (data register) |
| memRdata | input | 16 | Read data from memory |
| aluFunc | output | 1 | ALU select: 0 add, 1 subtract |
| aluA | output | 16 | ALU first operand (accumulator) |
| aluB | output | 16 | ALU second operand (operand value or memory word) |
| aluResult | input | 16 | ALU result |
| aluOvf | input | 1 | ALU signed overflow |
| irqReq | input | 1 | Interrupt request, level |
| irqAck | output | 1 | High in the register save cycle |
| pcOut | output | 12 | Program counter |
| accOut | output | 16 | Accumulator |
| cirOut | output | 16 | Current instruction register |
| statusOut | output | 4 | Flags: bit0 zero, bit1 negative, bit2 overflow, bit3 interrupt enable |
| halted | output | 1 | Sequencer frozen by halt |

## Verification
A wrong state step moves every later memory strobe by one or more cycles. For that reason the bench predicts the cycle number, kind and address of every memory access and acknowledge, and a sequencing fault shows up at the first access after it. Faults in the ALU path and the flags show in the accumulator and status outputs one cycle after the execute step. A bad save or restore shows as a wrong fetch address right after the return. A store placed just after the return exposes a corrupted accumulator in its write data.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_NOP  = 4'h0;
  localparam logic [OPW-1:0] OP_LDI  = 4'h1;
  localparam logic [OPW-1:0] OP_LDM  = 4'h2;
  localparam logic [OPW-1:0] OP_STM  = 4'h3;
  localparam logic [OPW-1:0] OP_JMP  = 4'h8;
  localparam logic [OPW-1:0] OP_IEN  = 4'h9;
  localparam logic [OPW-1:0] OP_IDIS = 4'hA;
  localparam logic [OPW-1:0] OP_RTI  = 4'hE;
  localparam logic [OPW-1:0] OP_HLT  = 4'hF;

  typedef enum logic [3:0] {
    S_FADDR, S_FINC, S_FMDR, S_FCIR, S_DEC,
    S_OADDR, S_ORD, S_OMDR, S_EXEC, S_SAVE, S_HALT
  } state_t;

  typedef struct packed {
    logic marFromPc;
    logic marFromOpr;
    logic pcInc;
    logic pcJump;
    logic pcIsr;
    logic mdrFromMem;
    logic mdrFromAcc;
    logic cirLoad;
    logic accFromOpr;
    logic accFromMdr;
    logic accFromAlu;
    logic aluSub;
    logic aluUseMdr;
    logic ieSet;
    logic ieClr;
    logic saveRegs;
    logic restoreRegs;
    logic memRe;
    logic memWe;
  } strobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [OPW-1:0] opcode,
  input  logic           ieBit,
  input  logic           irqReq,
  output strobe_t        ctl,
  output state_t         state,
  output logic           halted,
  output logic           irqAck
);

  state_t nxt;
  logic   isAlu;
  logic   needsRead;
  logic   isStore;

  assign isAlu     = (opcode[OPW-1:OPW-2] == 2'b01);
  assign needsRead = (opcode == OP_LDM) || (isAlu && opcode[0]);
  assign isStore   = (opcode == OP_STM);
  assign halted    = (state == S_HALT);
  assign irqAck    = (state == S_SAVE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FADDR;
    else       state <= nxt;
  end

  always_comb begin
    nxt           = state;
    ctl           = '0;
    ctl.aluSub    = opcode[1];
    ctl.aluUseMdr = opcode[0];
    unique case (state)
      S_FADDR: begin ctl.marFromPc = 1'b1; nxt = S_FINC; end
      S_FINC:  begin ctl.pcInc = 1'b1; ctl.memRe = 1'b1; nxt = S_FMDR; end
      S_FMDR:  begin ctl.mdrFromMem = 1'b1; nxt = S_FCIR; end
      S_FCIR:  begin ctl.cirLoad = 1'b1; nxt = S_DEC; end
      S_DEC:   nxt = (needsRead || isStore) ? S_OADDR : S_EXEC;
      S_OADDR: begin
        ctl.marFromOpr = 1'b1;
        ctl.mdrFromAcc = isStore;
        nxt = isStore ? S_EXEC : S_ORD;
      end
      S_ORD:   begin ctl.memRe = 1'b1; nxt = S_OMDR; end
      S_OMDR:  begin ctl.mdrFromMem = 1'b1; nxt = S_EXEC; end
      S_EXEC: begin
        case (opcode)
          OP_LDI:  ctl.accFromOpr  = 1'b1;
          OP_LDM:  ctl.accFromMdr  = 1'b1;
          OP_STM:  ctl.memWe       = 1'b1;
          OP_JMP:  ctl.pcJump      = 1'b1;
          OP_IEN:  ctl.ieSet       = 1'b1;
          OP_IDIS: ctl.ieClr       = 1'b1;
          OP_RTI:  ctl.restoreRegs = 1'b1;
          default: ctl.accFromAlu  = isAlu;
        endcase
        if (opcode == OP_HLT)      nxt = S_HALT;
        else if (irqReq && ieBit)  nxt = S_SAVE;
        else                       nxt = S_FADDR;
      end
      S_SAVE: begin
        ctl.saveRegs = 1'b1;
        ctl.pcIsr    = 1'b1;
        ctl.ieClr    = 1'b1;
        nxt = S_FADDR;
      end
      S_HALT:  nxt = S_HALT;
      default: nxt = S_FADDR;
    endcase
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int unsigned ISR_ADDR = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            ctl,
  input  logic [DW-1:0]      memRdata,
  input  logic [DW-1:0]      aluResult,
  input  logic               aluOvf,
  output logic [DW-OPW-1:0]  mar,
  output logic [DW-1:0]      mdr,
  output logic [DW-OPW-1:0]  pc,
  output logic [DW-1:0]      acc,
  output logic [DW-1:0]      cir,
  output logic [3:0]         sr,
  output logic [DW-1:0]      aluB
);

  localparam int AW = DW - OPW;

  logic [AW-1:0] operand;
  logic [DW-1:0] operandExt;
  logic [AW-1:0] shPc;
  logic [DW-1:0] shAcc;
  logic [3:0]    shSr;

  assign operand    = cir[AW-1:0];
  assign operandExt = {{OPW{1'b0}}, operand};
  assign aluB       = ctl.aluUseMdr ? mdr : operandExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mar   <= '0;
      mdr   <= '0;
      pc    <= '0;
      acc   <= '0;
      cir   <= '0;
      sr    <= '0;
      shPc  <= '0;
      shAcc <= '0;
      shSr  <= '0;
    end else begin
      if (ctl.marFromPc)       mar <= pc;
      else if (ctl.marFromOpr) mar <= operand;

      if (ctl.mdrFromMem)      mdr <= memRdata;
      else if (ctl.mdrFromAcc) mdr <= acc;

      if (ctl.cirLoad) cir <= mdr;

      if (ctl.restoreRegs)  pc <= shPc;
      else if (ctl.pcIsr)   pc <= AW'(ISR_ADDR);
      else if (ctl.pcJump)  pc <= operand;
      else if (ctl.pcInc)   pc <= pc + 1'b1;

      if (ctl.restoreRegs)     acc <= shAcc;
      else if (ctl.accFromOpr) acc <= operandExt;
      else if (ctl.accFromMdr) acc <= mdr;
      else if (ctl.accFromAlu) acc <= aluResult;

      if (ctl.restoreRegs) begin
        sr <= shSr;
      end else begin
        if (ctl.accFromAlu) sr[2:0] <= {aluOvf, aluResult[DW-1], aluResult == '0};
        if (ctl.ieSet)      sr[3]   <= 1'b1;
        else if (ctl.ieClr) sr[3]   <= 1'b0;
      end

      if (ctl.saveRegs) begin
        shPc  <= pc;
        shAcc <= acc;
        shSr  <= sr;
      end
    end
  end

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int unsigned ISR_ADDR = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic [DW-OPW-1:0]    memAddr,
  output logic                 memRe,
  output logic                 memWe,
  output logic [DW-1:0]        memWdata,
  input  logic [DW-1:0]        memRdata,
  output logic                 aluFunc,
  output logic [DW-1:0]        aluA,
  output logic [DW-1:0]        aluB,
  input  logic [DW-1:0]        aluResult,
  input  logic                 aluOvf,
  input  logic                 irqReq,
  output logic                 irqAck,
  output logic [DW-OPW-1:0]    pcOut,
  output logic [DW-1:0]        accOut,
  output logic [DW-1:0]        cirOut,
  output logic [3:0]           statusOut,
  output logic                 halted
);

  localparam int AW = DW - OPW;

  strobe_t       ctl;
  state_t        state;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr;
  logic [DW-1:0] cir;
  logic [3:0]    sr;

  seq_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (cir[DW-1:AW]),
    .ieBit  (sr[3]),
    .irqReq (irqReq),
    .ctl    (ctl),
    .state  (state),
    .halted (halted),
    .irqAck (irqAck)
  );

  seq_datapath #(.DW(DW), .ISR_ADDR(ISR_ADDR)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .memRdata  (memRdata),
    .aluResult (aluResult),
    .aluOvf    (aluOvf),
    .mar       (mar),
    .mdr       (mdr),
    .pc        (pcOut),
    .acc       (accOut),
    .cir       (cir),
    .sr        (sr),
    .aluB      (aluB)
  );

  assign memAddr   = mar;
  assign memWdata  = mdr;
  assign memRe     = ctl.memRe;
  assign memWe     = ctl.memWe;
  assign aluFunc   = ctl.aluSub;
  assign aluA      = accOut;
  assign cirOut    = cir;
  assign statusOut = sr;

endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int unsigned ISR_ADDR = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          memRe,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [AW-1:0] pcOut,
  input logic [3:0]    statusOut,
  input logic          irqAck,
  input logic          halted,
  input state_t        st
);

  // R4
  p_one_access_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R2: fetch read uses the current program counter
  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_FINC) |-> (memRe && memAddr == pcOut));

  // R2: program counter steps by one after the fetch read
  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_FINC) |=> (pcOut == AW'($past(pcOut) + 1'b1)));

  // R6 R9 R10 R12: status only moves after execute or save
  p_status_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusOut) |-> ($past(st) == S_EXEC || $past(st) == S_SAVE));

  // R10
  p_isr_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> (pcOut == AW'(ISR_ADDR) && !statusOut[3]));

  // R11
  p_ack_needs_ie_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> ($past(statusOut[3]) && $past(st) == S_EXEC));

  // R13
  p_halt_frozen_r13: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pcOut) && !memRe && !memWe));

endmodule

bind fetch_exec_seq seq_checker #(.AW(AW), .ISR_ADDR(ISR_ADDR)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .memRe     (memRe),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .pcOut     (pcOut),
  .statusOut (statusOut),
  .irqAck    (irqAck),
  .halted    (halted),
  .st        (uCtrl.state)
);

// File: tb/sim_fetch_exec_seq.sv
module sim_fetch_exec_seq;

  localparam int          DW  = 16;
  localparam int          AW  = 12;
  localparam int unsigned ISR = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic          memRe, memWe;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic          aluFunc;
  logic [DW-1:0] aluA, aluB, aluResult;
  logic          aluOvf;
  logic          irqReq = 1'b1;
  logic          irqAck;
  logic [AW-1:0] pcOut;
  logic [DW-1:0] accOut, cirOut;
  logic [3:0]    statusOut;
  logic          halted;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [DW-1:0] mem [64];

  typedef struct {
    int            when;
    int            kind;   // 0 read, 1 write, 2 acknowledge
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } ev_t;
  ev_t expQ[$];
  int  tCur = 0;
  logic [AW-1:0] pcExp = '0;

  fetch_exec_seq #(.DW(DW), .ISR_ADDR(ISR)) u0 (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .aluFunc(aluFunc), .aluA(aluA),
    .aluB(aluB), .aluResult(aluResult), .aluOvf(aluOvf), .irqReq(irqReq),
    .irqAck(irqAck), .pcOut(pcOut), .accOut(accOut), .cirOut(cirOut),
    .statusOut(statusOut), .halted(halted)
  );

  always #10 clk = ~clk;

  // environment: external ALU and synchronous memory
  assign aluResult = aluFunc ? aluA - aluB : aluA + aluB;
  assign aluOvf    = aluFunc ? ((aluA[15] != aluB[15]) && (aluResult[15] != aluA[15]))
                             : ((aluA[15] == aluB[15]) && (aluResult[15] != aluA[15]));

  always @(posedge clk) begin
    if (rstN) cyc <= cyc + 1;
    if (memWe) mem[memAddr[5:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[5:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int w, input int k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ev_t e;
    e.when = w; e.kind = k; e.addr = a; e.data = d;
    expQ.push_back(e);
  endtask

  // driver: predicted bus activity for one instruction (R2, R3)
  task automatic step(input logic [3:0] op, input logic [AW-1:0] opr, input logic [DW-1:0] wd);
    push(tCur + 1, 0, pcExp, '0);
    if (op == 4'h2 || op == 4'h5 || op == 4'h7) begin
      push(tCur + 6, 0, opr, '0);
      tCur += 9;
    end else if (op == 4'h3) begin
      push(tCur + 6, 1, opr, wd);
      tCur += 7;
    end else begin
      tCur += 6;
    end
    pcExp = pcExp + 1'b1;
  endtask

  task automatic waitCyc(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  // monitor: every strobe is compared with the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (memRe || memWe || irqAck)) begin
        int k;
        k = memWe ? 1 : (memRe ? 0 : 2);
        if (irqAck) irqReq = 1'b0;
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R3 R11 R13 unexpected event actual kind=%0d addr=%h cyc=%0d expected none",
                   k, memAddr, cyc);
        end else begin
          ev_t e;
          e = expQ.pop_front();
          if (e.when != cyc || e.kind != k || (k != 2 && e.addr != memAddr) ||
              (k == 1 && e.data != memWdata)) begin
            bad++;
            $display("FAIL R2 R3 R7 R10 event actual cyc=%0d kind=%0d addr=%h data=%h expected cyc=%0d kind=%0d addr=%h data=%h",
                     cyc, k, memAddr, memWdata, e.when, e.kind, e.addr, e.data);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = 16'h1005;  // load value 5
    mem[1]  = 16'h4003;  // add value 3
    mem[2]  = 16'h3030;  // store to 0x30
    mem[3]  = 16'h5031;  // add word at 0x31
    mem[4]  = 16'h2032;  // load word at 0x32
    mem[5]  = 16'h6008;  // subtract value 8
    mem[6]  = 16'h9000;  // enable interrupts
    mem[7]  = 16'h800A;  // jump to 0x0A
    mem[10] = 16'h3033;  // store to 0x33
    mem[11] = 16'hA000;  // disable interrupts
    mem[12] = 16'hF000;  // halt
    mem[32] = 16'h1077;  // service: load 0x77
    mem[33] = 16'h4001;  // add value 1
    mem[34] = 16'hE000;  // return
    mem[49] = 16'h7FF8;
    mem[50] = 16'h0008;

    step(4'h1, 12'h005, '0);
    step(4'h4, 12'h003, '0);
    step(4'h3, 12'h030, 16'h0008);
    step(4'h5, 12'h031, '0);
    step(4'h2, 12'h032, '0);
    step(4'h6, 12'h008, '0);
    step(4'h9, 12'h000, '0);
    step(4'h8, 12'h00A, '0);
    pcExp = 12'h00A;
    push(tCur, 2, '0, '0); tCur += 1; pcExp = AW'(ISR);
    step(4'h1, 12'h077, '0);
    step(4'h4, 12'h001, '0);
    step(4'hE, 12'h000, '0);
    pcExp = 12'h00A;
    step(4'h3, 12'h033, 16'h0000);
    step(4'hA, 12'h000, '0);
    step(4'hF, 12'h000, '0);

    repeat (3) @(negedge clk);
    chk("R1 pc", pcOut, 0);
    chk("R1 acc", accOut, 0);
    chk("R1 status", statusOut, 0);
    chk("R1 strobes", {halted, memRe, memWe, irqAck}, 0);
    rstN = 1'b1;

    waitCyc(28);
    chk("R6 R13 add word acc", accOut, 16'h8000);
    chk("R6 add word flags", statusOut, 4'b0110);
    waitCyc(37);
    chk("R5 load word acc", accOut, 16'h0008);
    chk("R5 load keeps flags", statusOut, 4'b0110);
    waitCyc(43);
    chk("R6 subtract acc", accOut, 16'h0000);
    chk("R6 subtract flags", statusOut, 4'b0001);
    waitCyc(49);
    chk("R9 enable bit", statusOut, 4'b1001);
    waitCyc(56);
    chk("R10 pc at service", pcOut, AW'(ISR));
    chk("R10 enable cleared", statusOut, 4'b0001);
    waitCyc(68);
    chk("R6 service add acc", accOut, 16'h0078);
    chk("R6 service flags", statusOut, 4'b0000);
    waitCyc(74);
    chk("R12 restored pc", pcOut, 12'h00A);
    chk("R12 restored acc", accOut, 16'h0000);
    chk("R12 restored status", statusOut, 4'b1001);
    waitCyc(88);
    chk("R9 disable bit", statusOut, 4'b0001);
    irqReq = 1'b1;  // R11: must be ignored
    waitCyc(100);
    chk("R13 halted", halted, 1'b1);
    chk("R8 R13 pc frozen", pcOut, 12'h00D);
    waitCyc(130);
    chk("R13 pc still frozen", pcOut, 12'h00D);
    chk("R11 no acknowledge", irqAck, 1'b0);
    chk("R13 all events seen", expQ.size(), 0);
    chk("R7 stored word", mem[48], 16'h0008);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule